// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small cache of page table entries used to turn a virtual address into a physical address without reading the page table in memory. Each of its slots holds a virtual page number as tag, a physical page number and a valid flag. Every slot is compared with the request at the same time. When one of them matches, the block forms the physical address in the same cycle by placing the stored physical page number above the untouched page offset.

When no slot matches, the block raises a miss output. An external page table walker then fetches the entry and returns it through the fill port. A returned entry is stored only if its page is resident in memory. It goes into an existing slot with the same tag if there is one. Otherwise it takes the lowest-numbered empty slot, and when every slot is occupied it takes the slot chosen by a rotating victim pointer. A flush input empties the whole buffer in one cycle.

Top module: `xlat_buf_top`

## Requirements
- R1: When `lookupValid` is high and a valid slot's tag equals the virtual page number (the upper VPN_W bits of `lookupVaddr`), `lookupHit` is high in the same cycle and `physAddr` equals that slot's physical page number concatenated above the low OFF_W offset bits of `lookupVaddr`.
- R2: When `lookupValid` is high and no valid slot matches, `lookupMiss` is high and `lookupHit` low. When `lookupValid` is low, both are low. `physAddr` is zero whenever `lookupHit` is low.
- R3: A fill with `fillResident` low is refused and leaves every slot unchanged.
- R4: A resident fill whose page number is not yet held goes into the lowest-numbered empty slot, so up to NUM_ENTRIES distinct pages are held without evicting any of them.
- R5: A resident fill of a new page number while all slots are full replaces the slot named by a victim pointer. The pointer starts at slot 0 after reset and advances by one, wrapping after the last slot, on each such replacement only.
- R6: A resident fill whose page number is already held overwrites that slot's physical page number and uses no second slot.
- R7: A high `flushAll` empties every slot by the next cycle and returns the victim pointer to slot 0. A fill in the same cycle as a flush is dropped.
- R8: After reset every slot is empty and every lookup misses.
- R9: A fill takes effect at the next clock edge. A lookup in the same cycle as the fill sees the buffer as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A translation request is present |
| lookupVaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lookupHit | output | 1 | Request matched a valid slot |
| lookupMiss | output | 1 | Request matched no valid slot |
| physAddr | output | PPN_W+OFF_W | Translated address, zero when not a hit |
| fillValid | input | 1 | Walker returns an entry |
| fillVpn | input | VPN_W | Virtual page number of the returned entry |
| fillPpn | input | PPN_W | Physical page number of the returned entry |
| fillResident | input | 1 | Returned page is resident in memory |
| flushAll | input | 1 | Empty the whole buffer |

## Verification
Two pairs of actions can land on the same edge. A flush can arrive with a resident fill, and a lookup can arrive with a fill of the page it asks for. The bench forces both pairs in directed steps. It then lets them recur in a long random run that draws page numbers from a pool slightly larger than the buffer, so hits, overwrites and evictions all occur. Each outcome is judged against a bench-side model in which the flush discards the fill and the lookup answers from the contents before the edge. The fill becomes visible only on the following lookup.

// File: rtl/xlat_buf_pkg.sv
package xlat_buf_pkg;
  // widest slot index the strobe struct carries (up to 256 slots)
  localparam int SLOT_W_MAX = 8;
  typedef logic [SLOT_W_MAX-1:0] slotIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     wrEn;    // write one slot this edge
    logic     clrAll;  // empty every slot this edge
    slotIdx_t slot;    // slot to write
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_buf_datapath.sv
module xlat_buf_datapath
  import xlat_buf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 16,
  parameter int PPN_W       = 12,
  parameter int OFF_W       = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [OFF_W-1:0]       lookupOff,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PPN_W-1:0]       fillPpn,
  input  xlatStrobe_t            ctrl,
  output logic                   lookupHit,
  output logic                   lookupMiss,
  output logic [PPN_W+OFF_W-1:0] physAddr,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] fillMatch
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [VPN_W-1:0]       tagQ [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppnQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ;
  logic [NUM_ENTRIES-1:0] lookMatch;
  logic [PPN_W-1:0]       hitPpn;
  logic [IDX_W-1:0]       wrIdx;

  assign wrIdx    = ctrl.slot[IDX_W-1:0];
  assign validVec = validQ;

  // parallel compare of every slot, for lookup and for fill
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    assign lookMatch[i] = validQ[i] && (tagQ[i] == lookupVpn);
    assign fillMatch[i] = validQ[i] && (tagQ[i] == fillVpn);
  end

  always_comb begin
    hitPpn = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lookMatch[i]) hitPpn = hitPpn | ppnQ[i];
    end
  end

  assign lookupHit  = lookupValid && (|lookMatch);
  assign lookupMiss = lookupValid && !(|lookMatch);
  assign physAddr   = lookupHit ? {hitPpn, lookupOff} : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (ctrl.clrAll) begin
      validQ <= '0;
    end else if (ctrl.wrEn) begin
      validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.wrEn && !ctrl.clrAll) begin
      tagQ[wrIdx] <= fillVpn;
      ppnQ[wrIdx] <= fillPpn;
    end
  end

  // R2: hit and miss are exclusive and silent without a request
  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(lookupHit && lookupMiss) && (lookupValid || (!lookupHit && !lookupMiss)));

  // R1: on a hit the offset passes through untouched
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> physAddr[OFF_W-1:0] == lookupOff);

  // R6: a page number is never held in two slots
  p_no_dup_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(fillMatch) <= 1);

  // R7: a flush leaves every slot empty on the next cycle
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrAll |=> validQ == '0);

  // R4: a new page with room left lands in an empty slot
  p_free_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrEn && !ctrl.clrAll && !(&validQ) && !(|fillMatch)) |-> !validQ[wrIdx]);
endmodule

// File: rtl/xlat_buf_ctrl.sv
module xlat_buf_ctrl
  import xlat_buf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fillValid,
  input  logic                   fillResident,
  input  logic                   flushAll,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] fillMatch,
  output xlatStrobe_t            ctrl
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             anyMatch;
  logic             anyFree;
  logic             accept;
  logic             replacing;

  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (fillMatch[i]) matchIdx = IDX_W'(i);
    end
  end

  // lowest empty slot: scan downwards so the lowest wins
  always_comb begin
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign anyMatch  = |fillMatch;
  assign anyFree   = !(&validVec);
  assign accept    = fillValid && fillResident && !flushAll;
  assign replacing = accept && !anyMatch && !anyFree;

  always_comb begin
    ctrl        = '0;
    ctrl.clrAll = flushAll;
    ctrl.wrEn   = accept;
    if (anyMatch)     ctrl.slot = slotIdx_t'(matchIdx);
    else if (anyFree) ctrl.slot = slotIdx_t'(freeIdx);
    else              ctrl.slot = slotIdx_t'(rrPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN || flushAll) begin
      rrPtr <= '0;
    end else if (replacing) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  // R3: a non-resident entry never produces a write
  p_reject_nonres_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillResident) |-> !ctrl.wrEn);

  // R7: a flush suppresses a same-cycle write
  p_flush_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> !ctrl.wrEn);

  // R5: replacing while full keeps the buffer full
  p_full_stays_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrEn && (&validVec)) |=> (&validVec));
endmodule

// File: rtl/xlat_buf_top.sv
module xlat_buf_top
  import xlat_buf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 16,
  parameter int PPN_W       = 12,
  parameter int OFF_W       = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [VPN_W+OFF_W-1:0] lookupVaddr,
  output logic                   lookupHit,
  output logic                   lookupMiss,
  output logic [PPN_W+OFF_W-1:0] physAddr,
  input  logic                   fillValid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic                   fillResident,
  input  logic                   flushAll
);
  xlatStrobe_t            ctrl;
  logic [NUM_ENTRIES-1:0] validVec;
  logic [NUM_ENTRIES-1:0] fillMatch;

  xlat_buf_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fillValid    (fillValid),
    .fillResident (fillResident),
    .flushAll     (flushAll),
    .validVec     (validVec),
    .fillMatch    (fillMatch),
    .ctrl         (ctrl)
  );

  xlat_buf_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .VPN_W       (VPN_W),
    .PPN_W       (PPN_W),
    .OFF_W       (OFF_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .lookupVpn   (lookupVaddr[VPN_W+OFF_W-1:OFF_W]),
    .lookupOff   (lookupVaddr[OFF_W-1:0]),
    .fillVpn     (fillVpn),
    .fillPpn     (fillPpn),
    .ctrl        (ctrl),
    .lookupHit   (lookupHit),
    .lookupMiss  (lookupMiss),
    .physAddr    (physAddr),
    .validVec    (validVec),
    .fillMatch   (fillMatch)
  );

  // R8: no hit in the first cycle after reset
  p_reset_empty_r8: assert property (@(posedge clk)
    $rose(rstN) |-> !lookupHit);
endmodule

// File: tb/xlat_buf_top_bench.sv
`timescale 1ns/1ps
module xlat_buf_top_bench;
  localparam int N     = 8;
  localparam int VPN_W = 16;
  localparam int PPN_W = 12;
  localparam int OFF_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [VPN_W+OFF_W-1:0] lookupVaddr = '0;
  logic lookupHit, lookupMiss;
  logic [PPN_W+OFF_W-1:0] physAddr;
  logic fillValid = 1'b0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [PPN_W-1:0] fillPpn = '0;
  logic fillResident = 1'b0;
  logic flushAll = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model
  bit               refV [N];
  logic [VPN_W-1:0] refT [N];
  logic [PPN_W-1:0] refP [N];
  int               refPtr;

  always #2.5 clk = ~clk;

  xlat_buf_top #(.NUM_ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_xlat_buf_top (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .lookupHit(lookupHit), .lookupMiss(lookupMiss), .physAddr(physAddr),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillResident(fillResident), .flushAll(flushAll)
  );

  function automatic void modelClear();
    for (int i = 0; i < N; i++) refV[i] = 1'b0;
    refPtr = 0;
  endfunction

  function automatic bit modelHit(input logic [VPN_W-1:0] vpn, output logic [PPN_W-1:0] ppn);
    ppn = '0;
    for (int i = 0; i < N; i++) begin
      if (refV[i] && refT[i] == vpn) begin
        ppn = refP[i];
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  function automatic void modelEdge(input bit fv, input logic [VPN_W-1:0] vpn,
                                    input logic [PPN_W-1:0] ppn, input bit res, input bit fl);
    int slot;
    if (fl) begin
      modelClear();
      return;
    end
    if (!(fv && res)) return;
    slot = -1;
    for (int i = 0; i < N; i++) if (refV[i] && refT[i] == vpn) slot = i;
    if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!refV[i]) slot = i;
    if (slot < 0) begin
      slot = refPtr;
      refPtr = (refPtr + 1) % N;
    end
    refV[slot] = 1'b1;
    refT[slot] = vpn;
    refP[slot] = ppn;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, then clock and update model
  task automatic step(input string req, input bit lv, input logic [VPN_W-1:0] lvpn,
                      input logic [OFF_W-1:0] loff, input bit fv, input logic [VPN_W-1:0] fvpn,
                      input logic [PPN_W-1:0] fppn, input bit fres, input bit fl);
    logic [PPN_W-1:0] ep;
    bit eh;
    lookupValid  = lv;
    lookupVaddr  = {lvpn, loff};
    fillValid    = fv;
    fillVpn      = fvpn;
    fillPpn      = fppn;
    fillResident = fres;
    flushAll     = fl;
    #1;
    eh = modelHit(lvpn, ep);
    check(req, "hit",  {31'b0, lookupHit},  {31'b0, lv && eh});
    check(req, "miss", {31'b0, lookupMiss}, {31'b0, lv && !eh});
    check(req, "paddr", 32'(physAddr), (lv && eh) ? 32'({ep, loff}) : 32'h0);
    @(posedge clk);
    modelEdge(fv, fvpn, fppn, fres, fl);
    @(negedge clk);
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off);
    step(req, 1'b1, vpn, off, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic fill(input string req, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input bit res);
    step(req, 1'b0, '0, '0, 1'b1, vpn, ppn, res, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R8: empty after reset
    look("R8", 16'h0010, 12'h001);
    look("R8", 16'h0000, 12'h000);
    // R2: idle request gives neither hit nor miss
    step("R2", 1'b0, 16'h0010, 12'h0, 1'b0, '0, '0, 1'b0, 1'b0);

    // R3: non-resident fill refused
    fill("R3", 16'h0010, 12'h0A1, 1'b0);
    look("R3", 16'h0010, 12'h123);

    // R9: lookup during the fill of the same page still misses
    step("R9", 1'b1, 16'h0010, 12'h5A5, 1'b1, 16'h0010, 12'h0A1, 1'b1, 1'b0);
    look("R1", 16'h0010, 12'h5A5);
    look("R1", 16'h0010, 12'hFFF);

    // R4: fill the remaining slots, nothing evicted
    for (int k = 1; k < N; k++) fill("R4", 16'(16'h0010 + k), 12'(12'h0A1 + k), 1'b1);
    for (int k = 0; k < N; k++) look("R4", 16'(16'h0010 + k), 12'(k * 3));

    // R6: refill of a held page overwrites in place
    fill("R6", 16'h0010, 12'h0B2, 1'b1);
    look("R6", 16'h0010, 12'h777);
    for (int k = 1; k < N; k++) look("R6", 16'(16'h0010 + k), 12'h010);

    // R5: full buffer, replacements walk the slots from 0
    fill("R5", 16'h0020, 12'h0C0, 1'b1);
    look("R5", 16'h0010, 12'h001);
    look("R5", 16'h0011, 12'h002);
    look("R5", 16'h0020, 12'h003);
    fill("R5", 16'h0021, 12'h0C1, 1'b1);
    look("R5", 16'h0011, 12'h004);
    look("R5", 16'h0012, 12'h005);

    // R7: flush together with a fill; the fill is dropped
    step("R7", 1'b1, 16'h0012, 12'h0, 1'b1, 16'h0030, 12'h0D0, 1'b1, 1'b1);
    look("R7", 16'h0030, 12'h006);
    look("R7", 16'h0012, 12'h007);
    look("R7", 16'h0020, 12'h008);
    // R7: pointer back at slot 0 after flush
    for (int k = 0; k < N; k++) fill("R7", 16'(16'h0040 + k), 12'(12'h0E0 + k), 1'b1);
    fill("R7", 16'h0050, 12'h0F0, 1'b1);
    look("R7", 16'h0040, 12'h009);
    look("R7", 16'h0041, 12'h00A);

    // random mix: small page pool so hits, overwrites and evictions recur
    for (int c = 0; c < 4000; c++) begin
      bit lv, fv, fres, fl;
      logic [VPN_W-1:0] lvpn, fvpn;
      lv   = ($urandom % 4) != 0;
      fv   = ($urandom % 5) < 2;
      fres = ($urandom % 5) != 0;
      fl   = ($urandom % 50) == 0;
      lvpn = 16'(16'h0100 + ($urandom % 12));
      fvpn = ($urandom % 4 == 0) ? lvpn : 16'(16'h0100 + ($urandom % 12));
      step(fl ? "R7" : (fv ? "R5" : "R1"), lv, lvpn, 12'($urandom), fv, fvpn,
           12'($urandom), fres, fl);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule